// File: doc/BRIEF.md
# Cache Line Burst Request Generator

This block sits between a cache controller and a 128-bit AXI master port. The cache side hands it one request at a time: a line fill, a write-back eviction, a partial write made on read allocation, or a non-cacheable access. The block turns each request into the address-channel fields of one burst: burst type, length, size, start address, direction and exclusive flag.

Only a small fixed set of bursts is legal. Line fills are wrapping bursts that start at the beat holding the critical word. No burst may cross a 64-byte line. When a request falls outside that set, the block flags an error for one cycle and issues nothing. Requests enter through a valid/ready pair, and the result sits in a single registered output stage with its own valid/ready pair.

Kind encoding on `req_kind`: 0 = line fill, 1 = eviction, 2 = read-allocate write, 3 = non-cacheable. `req_beats` is the number of beats (not minus one). `req_size` is log2 of the bytes per beat.

Top module: `brg_burst_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid` and `out_err` are 0.
- R2: A line fill with 4 beats and size 4 gives a burst with `out_burst`=2'b10 (WRAP), `out_len`=3 and `out_size`=4. `out_addr` is the request address with bits [3:0] cleared, and `out_write`=0. For a line fill, `req_write` is ignored.
- R3: A line fill whose beat count is not 4 or whose size is not 4 is illegal.
- R4: An eviction is legal only with 4 beats, size 4 and address bits [5:0] zero. It gives `out_burst`=2'b01 (INCR), `out_len`=3 and `out_write`=1.
- R5: A read-allocate write, or a multi-beat non-cacheable access, is legal only with 1, 2 or 4 beats, size 4 and address bits [3:0] zero. It gives INCR with `out_len` = beats − 1. A beat count of 0 or 3 is illegal for every kind.
- R6: A multi-beat INCR request whose beats would run past the end of its 64-byte line (address bits [5:4] + beats > 4) is illegal.
- R7: A single-beat non-cacheable access may have size 0 to 4 and must be aligned to 2^size bytes. A size above 4, or a misaligned address, is illegal. `out_write` follows `req_write` only for this kind; read-allocate writes and evictions always give 1.
- R8: `req_excl`=1 is legal only on a single-beat non-cacheable access, and it is copied to `out_excl`.
- R9: `out_burst` is never 2'b00 (FIXED) while `out_valid` is 1.
- R10: `req_ready` = !`out_valid` || `out_ready`. While `out_valid` is 1 and `out_ready` is 0, every output field holds its value.
- R11: An accepted illegal request raises `out_err` for exactly the next cycle, with `out_valid` low, and issues no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when high with req_valid |
| req_kind | input | 2 | Request kind (0 fill, 1 evict, 2 allocate write, 3 non-cacheable) |
| req_write | input | 1 | Direction for non-cacheable requests |
| req_excl | input | 1 | Exclusive access |
| req_addr | input | ADDR_W | Byte address |
| req_beats | input | BEATS_W | Beat count, 1-based |
| req_size | input | 3 | log2 of bytes per beat |
| out_valid | output | 1 | Burst fields valid |
| out_ready | input | 1 | Downstream takes the burst |
| out_write | output | 1 | 1 = write address channel, 0 = read |
| out_excl | output | 1 | Exclusive flag |
| out_burst | output | 2 | 01 INCR, 10 WRAP |
| out_len | output | 8 | Beats minus one |
| out_size | output | 3 | log2 bytes per beat |
| out_addr | output | ADDR_W | Burst start address |
| out_err | output | 1 | One-cycle illegal-request flag |

## Verification
Line fills are sent with critical words in different beat slots and with low address bits set. This shows that only the four low bits are cleared and that the burst wraps. Each INCR kind is tried at every legal beat count, then at start slots that just fit the line and slots that overrun it, to locate the crossing limit exactly. Single-beat accesses are swept over sizes with aligned and off-by-one addresses, and the exclusive flag is placed on legal and illegal shapes. A stretch with `out_ready` low, holding a queued request and releasing it, separates correct holding from overwrite or loss at the output stage.

// File: rtl/brg_pkg.sv
package brg_pkg;
  typedef enum logic [1:0] {
    K_FILL  = 2'd0,
    K_EVICT = 2'd1,
    K_ALLOC = 2'd2,
    K_NC    = 2'd3
  } kind_e;

  localparam logic [1:0] BT_INCR = 2'b01;
  localparam logic [1:0] BT_WRAP = 2'b10;

  typedef struct packed {
    logic       write;
    logic       excl;
    logic [1:0] burst;
    logic [7:0] len;
    logic [2:0] size;
  } fields_t;
endpackage

// File: rtl/brg_legal.sv
module brg_legal
  import brg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BYTES = 16,
  parameter int BEATS_W    = $clog2(LINE_BYTES / BEAT_BYTES) + 1
) (
  input  logic [1:0]         kind,
  input  logic               excl,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BEATS_W-1:0] beats,
  input  logic [2:0]         size,
  output logic               ok
);
  localparam int LINE_LSB  = $clog2(LINE_BYTES);
  localparam int BEAT_LSB  = $clog2(BEAT_BYTES);
  localparam int MAX_BEATS = LINE_BYTES / BEAT_BYTES;

  logic                pow2, size_ok, full_beat, beat_aln, line_aln, fits, size_aln, excl_ok, shape;
  logic [BEAT_LSB-1:0] low_mask;
  logic                single;

  always_comb begin
    single    = (beats == BEATS_W'(1));
    pow2      = (beats != '0) && ((beats & (beats - BEATS_W'(1))) == '0)
                && (int'(beats) <= MAX_BEATS);
    size_ok   = (int'(size) <= BEAT_LSB);
    full_beat = (int'(size) == BEAT_LSB);
    beat_aln  = (addr[BEAT_LSB-1:0] == '0);
    line_aln  = (addr[LINE_LSB-1:0] == '0);
    fits      = (int'(addr[LINE_LSB-1:BEAT_LSB]) + int'(beats)) <= MAX_BEATS;
    low_mask  = BEAT_LSB'((32'd1 << size) - 32'd1);
    size_aln  = ((addr[BEAT_LSB-1:0] & low_mask) == '0);
    excl_ok   = !excl || ((kind == K_NC) && single);
    unique case (kind)
      K_FILL:  shape = (int'(beats) == MAX_BEATS) && full_beat;
      K_EVICT: shape = (int'(beats) == MAX_BEATS) && full_beat && line_aln;
      K_ALLOC: shape = full_beat && beat_aln && fits;
      default: shape = single ? size_aln : (full_beat && beat_aln && fits);
    endcase
    ok = excl_ok && size_ok && pow2 && shape;
  end
endmodule

// File: rtl/brg_fields.sv
module brg_fields
  import brg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 16,
  parameter int BEATS_W    = 3
) (
  input  logic [1:0]         kind,
  input  logic               wr,
  input  logic               excl,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BEATS_W-1:0] beats,
  input  logic [2:0]         size,
  output fields_t            fld,
  output logic [ADDR_W-1:0]  start_addr
);
  localparam int BEAT_LSB = $clog2(BEAT_BYTES);

  always_comb begin
    fld.excl  = excl;
    fld.size  = size;
    fld.len   = 8'(beats) - 8'd1;
    fld.burst = (kind == K_FILL) ? BT_WRAP : BT_INCR;
    unique case (kind)
      K_FILL:  fld.write = 1'b0;
      K_NC:    fld.write = wr;
      default: fld.write = 1'b1;
    endcase
    start_addr = addr;
    if (kind == K_FILL) start_addr[BEAT_LSB-1:0] = '0;
  end
endmodule

// File: rtl/brg_burst_gen.sv
module brg_burst_gen
  import brg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BYTES = 16,
  parameter int BEATS_W    = $clog2(LINE_BYTES / BEAT_BYTES) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_kind,
  input  logic               req_write,
  input  logic               req_excl,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [BEATS_W-1:0] req_beats,
  input  logic [2:0]         req_size,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_write,
  output logic               out_excl,
  output logic [1:0]         out_burst,
  output logic [7:0]         out_len,
  output logic [2:0]         out_size,
  output logic [ADDR_W-1:0]  out_addr,
  output logic               out_err
);
  logic              legal, accept;
  fields_t           nxt_fld, cur_fld;
  logic [ADDR_W-1:0] nxt_addr;

  brg_legal #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .BEAT_BYTES(BEAT_BYTES), .BEATS_W(BEATS_W)
  ) u_legal (
    .kind(req_kind), .excl(req_excl), .addr(req_addr),
    .beats(req_beats), .size(req_size), .ok(legal)
  );

  brg_fields #(
    .ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES), .BEATS_W(BEATS_W)
  ) u_fields (
    .kind(req_kind), .wr(req_write), .excl(req_excl), .addr(req_addr),
    .beats(req_beats), .size(req_size), .fld(nxt_fld), .start_addr(nxt_addr)
  );

  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_err <= accept && !legal;
      if (accept)         out_valid <= legal;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && legal) begin
      cur_fld  <= nxt_fld;
      out_addr <= nxt_addr;
    end
  end

  assign out_write = cur_fld.write;
  assign out_excl  = cur_fld.excl;
  assign out_burst = cur_fld.burst;
  assign out_len   = cur_fld.len;
  assign out_size  = cur_fld.size;
endmodule

// File: rtl/brg_burst_gen_sva.sv
module brg_burst_gen_sva #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BYTES = 16,
  parameter int BEATS_W    = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [1:0]         req_kind,
  input logic               req_write,
  input logic               req_excl,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [BEATS_W-1:0] req_beats,
  input logic [2:0]         req_size,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_write,
  input logic               out_excl,
  input logic [1:0]         out_burst,
  input logic [7:0]         out_len,
  input logic [2:0]         out_size,
  input logic [ADDR_W-1:0]  out_addr,
  input logic               out_err
);
  localparam int LINE_LSB  = $clog2(LINE_BYTES);
  localparam int BEAT_LSB  = $clog2(BEAT_BYTES);
  localparam int MAX_BEATS = LINE_BYTES / BEAT_BYTES;

  a_r9_no_fixed: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_burst != 2'b00);

  a_r2_wrap_shape: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_burst == 2'b10) |->
      (int'(out_len) == MAX_BEATS - 1) && (int'(out_size) == BEAT_LSB)
      && !out_write && (out_addr[BEAT_LSB-1:0] == '0));

  a_r6_no_cross: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_burst == 2'b01 && int'(out_size) == BEAT_LSB) |->
      (int'(out_addr[LINE_LSB-1:BEAT_LSB]) + int'(out_len)) < MAX_BEATS);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      out_valid && $stable(out_addr) && $stable(out_len) && $stable(out_burst)
      && $stable(out_size) && $stable(out_write) && $stable(out_excl));

  a_r10_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !req_ready);

  a_r11_err_no_burst: assert property (@(posedge clk) disable iff (rst)
    out_err |-> !out_valid);
endmodule

bind brg_burst_gen brg_burst_gen_sva #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .BEAT_BYTES(BEAT_BYTES), .BEATS_W(BEATS_W)
) u_sva (.*);

// File: tb/brg_burst_gen_test.sv
module brg_burst_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int BEATS_W    = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0, req_ready;
  logic [1:0]        req_kind = '0;
  logic              req_write = 1'b0, req_excl = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [BEATS_W-1:0] req_beats = '0;
  logic [2:0]        req_size = '0;
  logic              out_valid, out_ready = 1'b1, out_write, out_excl, out_err;
  logic [1:0]        out_burst;
  logic [7:0]        out_len;
  logic [2:0]        out_size;
  logic [ADDR_W-1:0] out_addr;

  brg_burst_gen uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0, n_fail = 0;
  string cur_req = "R1";
  bit    run_cmp = 0;
  bit    done = 0;

  // reference state
  bit          m_valid = 0, m_err = 0, m_write = 0, m_excl = 0;
  int          m_burst = 0, m_len = 0, m_size = 0;
  longint      m_addr = 0;

  function automatic bit ref_legal(int kind, bit excl, longint addr, int beats, int size);
    longint off;
    off = addr % 64;
    if (size > 4) return 0;
    if (!(beats == 1 || beats == 2 || beats == 4)) return 0;
    if (excl && !(kind == 3 && beats == 1)) return 0;
    case (kind)
      0: return beats == 4 && size == 4;
      1: return beats == 4 && size == 4 && off == 0;
      default: begin
        if (kind == 3 && beats == 1) return (addr % (longint'(1) << size)) == 0;
        return size == 4 && (off % 16) == 0 && (off + 16 * beats) <= 64;
      end
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 0; m_err = 0;
    end else begin
      bit acc;
      acc   = req_valid && (!m_valid || out_ready);
      m_err = 0;
      if (acc) begin
        if (ref_legal(int'(req_kind), req_excl, longint'(req_addr), int'(req_beats), int'(req_size))) begin
          m_valid = 1;
          m_write = (req_kind == 0) ? 1'b0 : (req_kind == 3) ? req_write : 1'b1;
          m_excl  = req_excl;
          m_burst = (req_kind == 0) ? 2 : 1;
          m_len   = int'(req_beats) - 1;
          m_size  = int'(req_size);
          m_addr  = (req_kind == 0) ? (longint'(req_addr) / 16) * 16 : longint'(req_addr);
        end else begin
          m_valid = 0; m_err = 1;
        end
      end else if (out_ready) m_valid = 0;
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp && !done) begin
      chk("out_valid", 64'(out_valid), 64'(m_valid));
      chk("out_err", 64'(out_err), 64'(m_err));
      chk("req_ready", 64'(req_ready), 64'(!m_valid || out_ready));
      if (m_valid) begin
        chk("out_burst", 64'(out_burst), 64'(m_burst));
        chk("out_len", 64'(out_len), 64'(m_len));
        chk("out_size", 64'(out_size), 64'(m_size));
        chk("out_addr", 64'(out_addr), 64'(m_addr));
        chk("out_write", 64'(out_write), 64'(m_write));
        chk("out_excl", 64'(out_excl), 64'(m_excl));
      end
    end
  end

  task automatic send(string tag, int kind, bit wr, bit ex, longint addr, int beats, int size);
    cur_req   = tag;
    req_valid = 1'b1;
    req_kind  = 2'(kind);
    req_write = wr;
    req_excl  = ex;
    req_addr  = ADDR_W'(addr);
    req_beats = BEATS_W'(beats);
    req_size  = 3'(size);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(posedge clk);
    @(negedge clk);
    run_cmp = 1;
    cur_req = "R1";
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset release (also checked every cycle above)
    chk("r1_idle", 64'(out_valid | out_err), 64'd0);

    // R2: wrapping fills, critical word in various slots, write ignored
    send("R2", 0, 0, 0, 64'h1234_5678, 4, 4);
    send("R2", 0, 1, 0, 64'h0000_00FF, 4, 4);
    send("R2", 0, 0, 0, 64'h0000_1040, 4, 4);
    // R3: malformed fills
    send("R3", 0, 0, 0, 64'h100, 2, 4);
    send("R3", 0, 0, 0, 64'h100, 4, 3);
    send("R3", 0, 0, 0, 64'h100, 3, 4);
    // R4: evictions
    send("R4", 1, 0, 0, 64'h2000, 4, 4);
    send("R4", 1, 0, 0, 64'h2010, 4, 4);
    send("R4", 1, 0, 0, 64'h2040, 2, 4);
    // R5: allocate and non-cacheable multi-beat
    send("R5", 2, 0, 0, 64'h0020, 2, 4);
    send("R5", 2, 0, 0, 64'h0000, 4, 4);
    send("R5", 2, 0, 0, 64'h0030, 1, 4);
    send("R5", 2, 0, 0, 64'h0000, 3, 4);
    send("R5", 3, 0, 0, 64'h0000, 0, 4);
    send("R5", 2, 0, 0, 64'h0008, 1, 4);
    send("R5", 2, 0, 0, 64'h0000, 2, 3);
    send("R5", 3, 0, 0, 64'h0040, 4, 4);
    send("R5", 3, 1, 0, 64'h0060, 2, 4);
    // R6: line crossing
    send("R6", 2, 0, 0, 64'h0030, 2, 4);
    send("R6", 3, 1, 0, 64'h0010, 4, 4);
    send("R6", 3, 0, 0, 64'h0050, 2, 4);
    // R7: single-beat sizes and alignment
    send("R7", 3, 1, 0, 64'h0104, 1, 2);
    send("R7", 3, 1, 0, 64'h0106, 1, 2);
    send("R7", 3, 0, 0, 64'h0007, 1, 0);
    send("R7", 3, 0, 0, 64'h0108, 1, 3);
    send("R7", 3, 0, 0, 64'h010C, 1, 3);
    send("R7", 3, 0, 0, 64'h0110, 1, 5);
    send("R7", 3, 1, 0, 64'h0002, 1, 1);
    // R8: exclusive flag
    send("R8", 3, 1, 1, 64'h0008, 1, 3);
    send("R8", 3, 0, 1, 64'h0000, 2, 4);
    send("R8", 1, 0, 1, 64'h0000, 4, 4);
    send("R8", 2, 0, 1, 64'h0000, 1, 4);
    // R11: back-to-back illegal then legal
    send("R11", 3, 0, 0, 64'h0001, 1, 4);
    send("R11", 0, 0, 0, 64'h0000, 1, 4);
    send("R11", 1, 0, 0, 64'h0080, 4, 4);
    @(negedge clk);

    // R10: backpressure with a queued request
    cur_req   = "R10";
    out_ready = 1'b0;
    send("R10", 1, 0, 0, 64'h3000, 4, 4);
    req_valid = 1'b1;
    req_kind  = 2'd3; req_write = 1'b0; req_excl = 1'b0;
    req_addr  = 32'h0000_0040; req_beats = 3'd4; req_size = 3'd4;
    repeat (3) @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    out_ready = 1'b0;
    repeat (2) @(negedge clk);
    out_ready = 1'b1;
    // R9: FIXED never seen across the whole run is covered by out_burst compares
    cur_req = "R9";
    send("R9", 3, 1, 0, 64'h0020, 2, 4);
    repeat (3) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule